// File: doc/BRIEF.md
# Dual-Path Redundant Row Rotation

This block applies the byte row rotation of the AES round, or its inverse, to a 128-bit state that arrives twice, once on each of two redundant paths, A and B. The state is a 4x4 byte matrix filled column by column. Row r is rotated by r byte positions: to the left in the forward direction, to the right in the inverse direction.

The two copies never travel as whole bytes of one path. Before the rotation they are woven into two mixed words, and every byte of a mixed word holds bits from both paths. The rotation moves these mixed words. Afterwards the bits are sorted back into a path-A result and a path-B result. Because the two results are then compared, a wire fault inside the rotation corrupts only the bits of one path and raises the mismatch flag.

An optional output register stage, selected by a parameter, adds one cycle of latency. In the default build the stage is present. The flag has the same timing as the data.

Top module: `dual_row_shift`

## Requirements
- R1: While `rst_n` is low, `a_out` and `b_out` read zero and `mismatch` reads 0.
- R2: State byte k (0..15) occupies bits [127-8k -: 8] of each state port. Its row is k mod 4 and its column is k div 4.
- R3: When `dir_inv` is 0, output byte (row r, column c) equals input byte (row r, column (c+r) mod 4). This applies to each path.
- R4: Row 0 leaves the block unchanged in both directions.
- R5: When `dir_inv` is 1, output byte (row r, column c) equals input byte (row r, column (c-r) mod 4). Feeding a forward result back in the inverse direction restores the original state.
- R6: When both paths carry the same state, `a_out` equals `b_out` and `mismatch` is 0.
- R7: `mismatch` is 1 exactly when the two input states presented in the same cycle differ, including a difference in a single bit.
- R8: The contents of path B have no effect on `a_out`, and the contents of path A have no effect on `b_out`. Each output is the rotation of its own input.
- R9: With the register stage present, the outputs and `mismatch` change one clock edge after the inputs. A change of `dir_inv` takes effect with the same one-cycle latency as the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| dir_inv | input | 1 | 0 rotates rows left (forward), 1 rotates rows right (inverse) |
| a_in | input | 128 | State on redundant path A |
| b_in | input | 128 | State on redundant path B |
| a_out | output | 128 | Rotated path-A state, after the bits are sorted back |
| b_out | output | 128 | Rotated path-B state, after the bits are sorted back |
| mismatch | output | 1 | Set when the recovered path states disagree |

## Verification
Two functions can act in the same cycle: a switch of rotation direction, and the detection of a difference between the paths. The bench provokes this by flipping `dir_inv` in the same cycle as it injects a single-bit difference on path B. One edge later it judges that path A carries the inverse rotation of its own input, that path B carries the inverse rotation of the faulty copy, and that `mismatch` is set. In the following cycle it restores clean, equal forward traffic and expects the flag to drop.

// File: rtl/rowrot_pkg.sv
package rowrot_pkg;

  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;

  // Source column feeding (row, col) for a given rotation sense.
  function automatic int src_column(int row, int col, int ncols, bit right);
    int s;
    if (right) s = (col - (row % ncols) + ncols) % ncols;
    else       s = (col + row) % ncols;
    return s;
  endfunction

  // Bit offset (from the LSB) of byte k in a word of nbytes bytes of width bw,
  // byte 0 being the most significant.
  function automatic int byte_lsb(int k, int nbytes, int bw);
    return (nbytes - 1 - k) * bw;
  endfunction

endpackage

// File: rtl/bit_weave.sv
// Swaps odd bit positions between two words, byte by byte.
// Even bits stay in their word, odd bits cross to the partner word.
// The mapping is its own inverse, so one module serves both to weave
// the paths together and to sort them apart again.
module bit_weave #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 16
) (
  input  logic [BYTE_W*N_BYTES-1:0] lane_x,
  input  logic [BYTE_W*N_BYTES-1:0] lane_y,
  output logic [BYTE_W*N_BYTES-1:0] mix_p,
  output logic [BYTE_W*N_BYTES-1:0] mix_q
);
  localparam int W = BYTE_W * N_BYTES;

  for (genvar p = 0; p < N_BYTES; p++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      localparam int POS = p * BYTE_W + i;
      if ((i % 2) == 0) begin : g_keep
        assign mix_p[POS] = lane_x[POS];
        assign mix_q[POS] = lane_y[POS];
      end else begin : g_cross
        assign mix_p[POS] = lane_y[POS];
        assign mix_q[POS] = lane_x[POS];
      end
    end
  end

  // W is kept for readers sizing neighbours
  if (W < 2) begin : g_width_guard
    initial $display("bit_weave: degenerate width %0d", W);
  end
endmodule

// File: rtl/row_rotator.sv
// Byte-granular row rotation of a column-major state matrix.
module row_rotator #(
  parameter int BYTE_W = 8,
  parameter int N_ROWS = 4,
  parameter int N_COLS = 4
) (
  input  logic                              inv,
  input  logic [BYTE_W*N_ROWS*N_COLS-1:0]   din,
  output logic [BYTE_W*N_ROWS*N_COLS-1:0]   dout
);
  import rowrot_pkg::*;

  localparam int N_BYTES = N_ROWS * N_COLS;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      localparam int DST   = c * N_ROWS + r;
      localparam int SRC_L = src_column(r, c, N_COLS, 1'b0) * N_ROWS + r;
      localparam int SRC_R = src_column(r, c, N_COLS, 1'b1) * N_ROWS + r;
      localparam int D_LSB = byte_lsb(DST,   N_BYTES, BYTE_W);
      localparam int L_LSB = byte_lsb(SRC_L, N_BYTES, BYTE_W);
      localparam int R_LSB = byte_lsb(SRC_R, N_BYTES, BYTE_W);

      always_comb begin
        if (inv == ROT_RIGHT) dout[D_LSB +: BYTE_W] = din[R_LSB +: BYTE_W];
        else                  dout[D_LSB +: BYTE_W] = din[L_LSB +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/path_compare.sv
// Per-byte disagreement map between the two recovered paths.
module path_compare #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 16
) (
  input  logic [BYTE_W*N_BYTES-1:0] path_a,
  input  logic [BYTE_W*N_BYTES-1:0] path_b,
  output logic [N_BYTES-1:0]        byte_diff
);
  for (genvar k = 0; k < N_BYTES; k++) begin : g_cmp
    assign byte_diff[k] = |(path_a[k*BYTE_W +: BYTE_W] ^ path_b[k*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/dual_row_shift.sv
module dual_row_shift #(
  parameter int BYTE_W  = 8,
  parameter int N_ROWS  = 4,
  parameter int N_COLS  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            dir_inv,
  input  logic [BYTE_W*N_ROWS*N_COLS-1:0] a_in,
  input  logic [BYTE_W*N_ROWS*N_COLS-1:0] b_in,
  output logic [BYTE_W*N_ROWS*N_COLS-1:0] a_out,
  output logic [BYTE_W*N_ROWS*N_COLS-1:0] b_out,
  output logic                            mismatch
);
  localparam int N_BYTES = N_ROWS * N_COLS;
  localparam int W       = BYTE_W * N_BYTES;
  localparam int ROW0_W  = BYTE_W * N_COLS;

  // named internal events
  logic [W-1:0]       woven_p, woven_q;
  logic [W-1:0]       rot_p, rot_q;
  logic [W-1:0]       a_rec, b_rec;
  logic [N_BYTES-1:0] diff_bytes;
  logic               mismatch_c;

  bit_weave #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_weave (
    .lane_x(a_in), .lane_y(b_in), .mix_p(woven_p), .mix_q(woven_q)
  );

  row_rotator #(.BYTE_W(BYTE_W), .N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_rot_p (
    .inv(dir_inv), .din(woven_p), .dout(rot_p)
  );

  row_rotator #(.BYTE_W(BYTE_W), .N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_rot_q (
    .inv(dir_inv), .din(woven_q), .dout(rot_q)
  );

  bit_weave #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_unweave (
    .lane_x(rot_p), .lane_y(rot_q), .mix_p(a_rec), .mix_q(b_rec)
  );

  path_compare #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cmp (
    .path_a(a_rec), .path_b(b_rec), .byte_diff(diff_bytes)
  );

  assign mismatch_c = |diff_bytes;

  if (REG_OUT) begin : g_reg
    logic armed_q;
    logic [ROW0_W-1:0] row0_in, row0_out;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_out    <= '0;
        b_out    <= '0;
        mismatch <= 1'b0;
        armed_q  <= 1'b0;
      end else begin
        a_out    <= a_rec;
        b_out    <= b_rec;
        mismatch <= mismatch_c;
        armed_q  <= 1'b1;
      end
    end

    for (genvar c = 0; c < N_COLS; c++) begin : g_row0
      localparam int LSB = (N_BYTES - 1 - c * N_ROWS) * BYTE_W;
      assign row0_in [c*BYTE_W +: BYTE_W] = a_in [LSB +: BYTE_W];
      assign row0_out[c*BYTE_W +: BYTE_W] = a_out[LSB +: BYTE_W];
    end

    // R7
    mismatch_tracks_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (mismatch == ($past(a_in) != $past(b_in))));

    // R4
    row0_unmoved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (row0_out == $past(row0_in)));

    // R3
    ones_preserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> ($countones(a_out) == $past($countones(a_in))));

    // R6
    paths_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mismatch |-> (a_out == b_out));

    // R8
    path_a_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(a_in) == $past(a_in, 2) && $past(dir_inv) == $past(dir_inv, 2)
       && $past(armed_q)) |-> $stable(a_out));
  end else begin : g_comb
    assign a_out    = a_rec;
    assign b_out    = b_rec;
    assign mismatch = mismatch_c;
  end
endmodule

// File: tb/dual_row_shift_bench.sv
`timescale 1ns/1ps
module dual_row_shift_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir_inv = 1'b0;
  logic [127:0] a_in = '0, b_in = '0;
  logic [127:0] a_out, b_out;
  logic         mismatch;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dual_row_shift u_dual_row_shift (
    .clk(clk), .rst_n(rst_n), .dir_inv(dir_inv),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out), .mismatch(mismatch)
  );

  // Reference model from the requirements: byte k at [127-8k -: 8], row k%4, col k/4.
  function automatic logic [127:0] ref_rot(input logic [127:0] x, input bit inv);
    logic [127:0] y;
    y = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        int s;
        s = inv ? (c + 4 - r) % 4 : (c + r) % 4;
        y[127-8*(4*c+r) -: 8] = x[127-8*(4*s+r) -: 8];
      end
    end
    return y;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input logic [127:0] a, input logic [127:0] b, input bit inv);
    @(negedge clk);
    a_in = a; b_in = b; dir_inv = inv;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a_in = {4{32'hA5C3_0F96}}; b_in = ~a_in;
    repeat (3) @(negedge clk);
    chk("R1 a_out", a_out, '0);
    chk("R1 b_out", b_out, '0);
    chk("R1 mismatch", {127'd0, mismatch}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_forward();
    logic [127:0] v;
    v = 128'h000102030405060708090a0b0c0d0e0f;
    present(v, v, 1'b0);
    chk("R2 R3 known forward", a_out, 128'h00050a0f04090e03080d02070c01060b);
    chk("R6 b_out equal", b_out, a_out);
    chk("R6 no mismatch", {127'd0, mismatch}, '0);
    v = 128'hdeadbeef_0123_4567_89ab_cdef_f00d_cafe;
    present(v, v, 1'b0);
    chk("R3 pattern2", a_out, ref_rot(v, 1'b0));
    chk("R6 pattern2 b", b_out, ref_rot(v, 1'b0));
  endtask

  task automatic t_inverse();
    logic [127:0] v, fwd;
    v = 128'h000102030405060708090a0b0c0d0e0f;
    present(v, v, 1'b1);
    chk("R5 known inverse", a_out, 128'h000d0a0704010e0b0805020f0c090603);
    for (int c = 0; c < 4; c++)
      chk("R4 row0 byte", {120'd0, a_out[127-32*c -: 8]}, {120'd0, v[127-32*c -: 8]});
    v = 128'h1f2e3d4c5b6a79880796a5b4c3d2e1f0;
    present(v, v, 1'b0);
    fwd = a_out;
    present(fwd, fwd, 1'b1);
    chk("R5 round trip", a_out, v);
  endtask

  task automatic t_latency();
    logic [127:0] v, prev;
    prev = a_out;
    v = 128'h0f0e0d0c0b0a09080706050403020100;
    @(negedge clk);
    a_in = v; b_in = v; dir_inv = 1'b0;
    #1;
    chk("R9 holds before edge", a_out, prev);
    @(negedge clk);
    chk("R9 after one edge", a_out, ref_rot(v, 1'b0));
  endtask

  task automatic t_fault();
    logic [127:0] a, b;
    int bits[4] = '{0, 1, 64, 127};
    a = 128'h3c3c_5a5a_9696_f0f0_0ff0_1234_8765_aa55;
    foreach (bits[i]) begin
      b = a ^ (128'd1 << bits[i]);
      present(a, b, 1'b0);
      chk("R7 single bit flagged", {127'd0, mismatch}, 128'd1);
      chk("R8 a_out own path", a_out, ref_rot(a, 1'b0));
      chk("R8 b_out own path", b_out, ref_rot(b, 1'b0));
    end
    present(a, a, 1'b0);
    chk("R7 flag clears", {127'd0, mismatch}, '0);
  endtask

  task automatic t_combined();
    logic [127:0] a, b;
    a = 128'h0123456789abcdeffedcba9876543210;
    b = a ^ (128'd1 << 77);
    present(a, a, 1'b0);
    present(a, b, 1'b1);
    chk("R9 R5 dir switch path A", a_out, ref_rot(a, 1'b1));
    chk("R8 dir switch path B", b_out, ref_rot(b, 1'b1));
    chk("R7 fault same cycle", {127'd0, mismatch}, 128'd1);
    present(a, a, 1'b0);
    chk("R9 back forward", a_out, ref_rot(a, 1'b0));
    chk("R7 clean again", {127'd0, mismatch}, '0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_forward();
    t_inverse();
    t_latency();
    t_fault();
    t_combined();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule